// File: doc/BRIEF.md
# Multicart CHR Bank Translator

This block sits between a scanline-counter bank-switching core and the pattern memory of a multi-game cartridge. For each of the eight 1 KB pattern slots, the core supplies a bank value. The translator turns each of these values into a final bank number in 1 KB units. It also selects whether pattern fetches go to RAM or to ROM. The result depends on three inputs: a mode control byte, an outer-bank byte and an extension control byte. Bit 7 of the core's command byte also matters, but only in the extension mode.

Three translation modes exist:
- **Single 8 KB page.** The outer byte, merged with a small latched value, picks one 8 KB page.
- **RAM passthrough.** Each core value goes through unchanged and pattern RAM is selected.
- **Outer-offset mode.** A 1 KB-granular offset taken from the outer byte is merged into every core value.

The outer-offset mode has an extension option. In it, four consecutive slots are filled from two core bank registers, interleaved with two local extra registers. These four slots sit in the low half of the window or in the high half, depending on the command bit.

The translation itself is combinational. Only the two extra registers and the latch are stored here. Each of them can be loaded through a one-cycle write strobe.

Top module: `chr_bank_xlat`

## Requirements
- R1: When bit 6 of `ctrl0_i` is 1, RAM is not selected. Slot s (0..7) maps to `{(outer_i | latch), s[2:0]}`, where latch is the 2-bit stored value zero-extended to 8 bits. This holds whatever bits 5 and 1 hold.
- R2: When bit 6 of `ctrl0_i` is 0 and bit 5 is 1, `chr_ram_o` is 1 and each slot's bank equals that slot's core value, zero-extended to 11 bits.
- R3: When bits 6 and 5 of `ctrl0_i` are both 0, `chr_ram_o` is 0. With bit 1 of `ext_ctrl_i` clear, each slot equals its core value ORed with `{outer_i[6:0], 3'b000}`. Bit 7 of `outer_i` and bit 7 of `core_cmd_i` have no effect.
- R4: In outer-offset mode with bit 1 of `ext_ctrl_i` set and bit 7 of `core_cmd_i` clear, slots 0, 1, 2 and 3 take `core_r0_i`, extra register A, `core_r1_i` and extra register B. Each is ORed with the offset. Slots 4 to 7 keep their core values ORed with the offset.
- R5: In the case of R4 with bit 7 of `core_cmd_i` set, the four substituted values move to slots 4, 5, 6 and 7 in the same order. Slots 0 to 3 take their core values ORed with the offset.
- R6: Reset, asynchronous and active-low, sets both extra registers to 0xFF and the latch to 0.
- R7: While `xr_we_i` is 1 at a rising clock edge, `xr_wdata_i` is loaded into extra register A (`xr_sel_i`=0) or extra register B (`xr_sel_i`=1). The new value is visible after that edge and not before. With `xr_we_i` low, the data is ignored.
- R8: While `lat_we_i` is 1 at a rising clock edge, `lat_wdata_i` is loaded into the latch, visible after that edge. With `lat_we_i` low, the data is ignored.
- R9: Outputs follow input changes in the same cycle with no register delay. With the inputs unchanged and no write, they hold.
- R10: The extension bit and the command bit have no effect in the single-page and RAM passthrough modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl0_i | input | 8 | Mode byte: bit 6 single page, bit 5 RAM passthrough |
| outer_i | input | 8 | Outer-bank byte |
| ext_ctrl_i | input | 8 | Extension byte: bit 1 enables slot substitution |
| core_cmd_i | input | 8 | Core command byte: bit 7 swaps pattern halves |
| core_r0_i | input | 8 | Core bank register 0 |
| core_r1_i | input | 8 | Core bank register 1 |
| core_slot_i | input | 64 | Core bank value per slot, slot s at bits [8s+7:8s] |
| xr_we_i | input | 1 | Extra register write strobe |
| xr_sel_i | input | 1 | Extra register select (0 = A, 1 = B) |
| xr_wdata_i | input | 8 | Extra register write data |
| lat_we_i | input | 1 | Latch write strobe |
| lat_wdata_i | input | 2 | Latch write data |
| chr_bank_o | output | 88 | Final 1 KB bank per slot, slot s at bits [11s+10:11s] |
| chr_ram_o | output | 1 | 1 selects pattern RAM, 0 selects ROM |

## Verification
The bench goes after the mode priority. It sets the single-page and RAM bits together, and it sets the extension bit in modes where the bit must be ignored. A decoder with the wrong order would show core values or substituted slots where the single-page pattern belongs.

The bench also flips the swap bit in extension mode. It checks the exact order of the four substituted slots, so a design that swaps the wrong half, or interleaves the two sources wrongly, fails on specific slots.

Finally, the bench checks the extra registers and the latch on both sides of the write edge, and again after an asynchronous reset taken mid-run. This catches an off-by-one-cycle update, a missed 0xFF reset value, and a latch that survives reset.

// File: rtl/chr_xlat_pkg.sv
package chr_xlat_pkg;

  // Control bit positions inside the mode, extension and command bytes.
  localparam int FLAT_BIT = 6;
  localparam int RAM_BIT  = 5;
  localparam int EXT_BIT  = 1;
  localparam int SWAP_BIT = 7;

  typedef enum logic [1:0] {
    MODE_FLAT8K    = 2'd0,
    MODE_RAM_PASS  = 2'd1,
    MODE_OUTER     = 2'd2,
    MODE_OUTER_EXT = 2'd3
  } chr_mode_e;

endpackage

// File: rtl/chr_xlat_rst_sync.sv
module chr_xlat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  // Assert at once, release two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/chr_xlat_regs.sv
module chr_xlat_regs #(
  parameter int CORE_W = 8,
  parameter int LAT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xr_we,
  input  logic              xr_sel,
  input  logic [CORE_W-1:0] xr_wdata,
  input  logic              lat_we,
  input  logic [LAT_W-1:0]  lat_wdata,
  output logic [CORE_W-1:0] xa_o,
  output logic [CORE_W-1:0] xb_o,
  output logic [LAT_W-1:0]  lat_o
);

  logic [CORE_W-1:0] xa_q, xa_d;
  logic [CORE_W-1:0] xb_q, xb_d;
  logic [LAT_W-1:0]  lat_q, lat_d;
  logic              upd_en;

  assign upd_en = xr_we | lat_we;

  always_comb begin
    xa_d  = xa_q;
    xb_d  = xb_q;
    lat_d = lat_q;
    if (xr_we) begin
      if (xr_sel) xb_d = xr_wdata;
      else        xa_d = xr_wdata;
    end
    if (lat_we) lat_d = lat_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xa_q  <= '1;
      xb_q  <= '1;
      lat_q <= '0;
    end else if (upd_en) begin
      xa_q  <= xa_d;
      xb_q  <= xb_d;
      lat_q <= lat_d;
    end
  end

  assign xa_o  = xa_q;
  assign xb_o  = xb_q;
  assign lat_o = lat_q;

endmodule

// File: rtl/chr_xlat_decode.sv
module chr_xlat_decode
  import chr_xlat_pkg::*;
#(
  parameter int CORE_W  = 8,
  parameter int BANK_W  = 11,
  parameter int OUTER_W = 7,
  parameter int LAT_W   = 2,
  parameter int SUB_W   = 3
) (
  input  logic              flat_bit,
  input  logic              ram_bit,
  input  logic              ext_bit,
  input  logic [CORE_W-1:0] outer,
  input  logic [LAT_W-1:0]  latch,
  output chr_mode_e         mode,
  output logic [BANK_W-1:0] base,
  output logic [CORE_W-1:0] flat_page
);

  // Priority: single page, then RAM passthrough, then offset modes.
  always_comb begin
    if (flat_bit)     mode = MODE_FLAT8K;
    else if (ram_bit) mode = MODE_RAM_PASS;
    else if (ext_bit) mode = MODE_OUTER_EXT;
    else              mode = MODE_OUTER;
  end

  assign base      = BANK_W'({outer[OUTER_W-1:0], {SUB_W{1'b0}}});
  assign flat_page = outer | CORE_W'(latch);

endmodule

// File: rtl/chr_xlat_slot.sv
module chr_xlat_slot
  import chr_xlat_pkg::*;
#(
  parameter int CORE_W = 8,
  parameter int BANK_W = 11,
  parameter int SUB_W  = 3,
  parameter int IDX    = 0
) (
  input  chr_mode_e         mode,
  input  logic [BANK_W-1:0] base,
  input  logic [CORE_W-1:0] flat_page,
  input  logic [CORE_W-1:0] core_val,
  input  logic              ovr_en,
  input  logic [CORE_W-1:0] ovr_val,
  output logic [BANK_W-1:0] bank_o
);

  localparam logic [SUB_W-1:0] SUB_IDX = SUB_W'(IDX);

  logic [CORE_W-1:0] pick;

  assign pick = ovr_en ? ovr_val : core_val;

  always_comb begin
    unique case (mode)
      MODE_FLAT8K:    bank_o = BANK_W'({flat_page, SUB_IDX});
      MODE_RAM_PASS:  bank_o = BANK_W'(core_val);
      MODE_OUTER:     bank_o = BANK_W'(core_val) | base;
      MODE_OUTER_EXT: bank_o = BANK_W'(pick) | base;
      default:        bank_o = '0;
    endcase
  end

endmodule

// File: rtl/chr_bank_xlat.sv
module chr_bank_xlat
  import chr_xlat_pkg::*;
#(
  parameter int CORE_W  = 8,
  parameter int BANK_W  = 11,
  parameter int NSLOT   = 8,
  parameter int OUTER_W = 7,
  parameter int LAT_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              ctrl0_i,
  input  logic [CORE_W-1:0]       outer_i,
  input  logic [7:0]              ext_ctrl_i,
  input  logic [7:0]              core_cmd_i,
  input  logic [CORE_W-1:0]       core_r0_i,
  input  logic [CORE_W-1:0]       core_r1_i,
  input  logic [NSLOT*CORE_W-1:0] core_slot_i,
  input  logic                    xr_we_i,
  input  logic                    xr_sel_i,
  input  logic [CORE_W-1:0]       xr_wdata_i,
  input  logic                    lat_we_i,
  input  logic [LAT_W-1:0]        lat_wdata_i,
  output logic [NSLOT*BANK_W-1:0] chr_bank_o,
  output logic                    chr_ram_o
);

  localparam int SUB_W = $clog2(NSLOT);
  localparam int HALF  = NSLOT / 2;

  logic              rst_n_sync;
  logic [CORE_W-1:0] xa, xb;
  logic [LAT_W-1:0]  latch;
  chr_mode_e         mode;
  logic [BANK_W-1:0] base;
  logic [CORE_W-1:0] flat_page;
  logic              swap;

  // Control bits that do not take part in pattern translation.
  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl0_i[7], ctrl0_i[4:0], ext_ctrl_i[7:2],
                         ext_ctrl_i[0], core_cmd_i[6:0]};

  assign swap = core_cmd_i[SWAP_BIT];

  chr_xlat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  chr_xlat_regs #(
    .CORE_W (CORE_W),
    .LAT_W  (LAT_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .xr_we     (xr_we_i),
    .xr_sel    (xr_sel_i),
    .xr_wdata  (xr_wdata_i),
    .lat_we    (lat_we_i),
    .lat_wdata (lat_wdata_i),
    .xa_o      (xa),
    .xb_o      (xb),
    .lat_o     (latch)
  );

  chr_xlat_decode #(
    .CORE_W  (CORE_W),
    .BANK_W  (BANK_W),
    .OUTER_W (OUTER_W),
    .LAT_W   (LAT_W),
    .SUB_W   (SUB_W)
  ) u_dec (
    .flat_bit  (ctrl0_i[FLAT_BIT]),
    .ram_bit   (ctrl0_i[RAM_BIT]),
    .ext_bit   (ext_ctrl_i[EXT_BIT]),
    .outer     (outer_i),
    .latch     (latch),
    .mode      (mode),
    .base      (base),
    .flat_page (flat_page)
  );

  assign chr_ram_o = (mode == MODE_RAM_PASS);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam int HALF_IDX = s / HALF;
    localparam int QTR      = s % HALF;

    logic [CORE_W-1:0] ovr_val;
    logic              ovr_en;

    // Substitution order inside the selected half: r0, A, r1, B.
    if (QTR == 0) begin : g_q0
      assign ovr_val = core_r0_i;
    end else if (QTR == 1) begin : g_q1
      assign ovr_val = xa;
    end else if (QTR == 2) begin : g_q2
      assign ovr_val = core_r1_i;
    end else begin : g_q3
      assign ovr_val = xb;
    end

    assign ovr_en = (QTR < 4) && (swap == (HALF_IDX == 1));

    chr_xlat_slot #(
      .CORE_W (CORE_W),
      .BANK_W (BANK_W),
      .SUB_W  (SUB_W),
      .IDX    (s)
    ) u_slot (
      .mode      (mode),
      .base      (base),
      .flat_page (flat_page),
      .core_val  (core_slot_i[s*CORE_W +: CORE_W]),
      .ovr_en    (ovr_en),
      .ovr_val   (ovr_val),
      .bank_o    (chr_bank_o[s*BANK_W +: BANK_W])
    );
  end

endmodule

// File: rtl/chr_bank_xlat_chk.sv
module chr_bank_xlat_chk #(
  parameter int CORE_W  = 8,
  parameter int BANK_W  = 11,
  parameter int NSLOT   = 8,
  parameter int OUTER_W = 7
) (
  input logic                    clk,
  input logic                    rst_n_sync,
  input logic                    flat_bit,
  input logic                    ram_bit,
  input logic                    ext_bit,
  input logic                    swap_bit,
  input logic [OUTER_W-1:0]      outer_lo,
  input logic                    outer_hi,
  input logic [CORE_W-1:0]       core_r0,
  input logic [CORE_W-1:0]       core_r1,
  input logic [NSLOT*CORE_W-1:0] core_slot,
  input logic                    xr_we,
  input logic                    xr_sel,
  input logic [CORE_W-1:0]       xr_wdata,
  input logic                    lat_we,
  input logic [NSLOT*BANK_W-1:0] chr_bank,
  input logic                    chr_ram
);

  localparam int SUB_W = $clog2(NSLOT);

  logic [BANK_W-1:0] offs;
  assign offs = BANK_W'({outer_lo, {SUB_W{1'b0}}});

  // R1
  flat_sub_index_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    flat_bit |-> (!chr_ram && chr_bank[2:0] == 3'd0
                  && chr_bank[(NSLOT-1)*BANK_W +: 3] == 3'(NSLOT-1)));

  // R2
  ram_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!flat_bit && ram_bit) |->
      (chr_ram && chr_bank[2*BANK_W +: BANK_W] == BANK_W'(core_slot[2*CORE_W +: CORE_W])));

  // R3
  outer_offset_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!flat_bit && !ram_bit) |->
      (!chr_ram && (chr_bank[6*BANK_W +: BANK_W] & offs) == offs));

  // R7
  extra_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($past(rst_n_sync) && $past(xr_we) && !$past(xr_sel)
     && !flat_bit && !ram_bit && ext_bit && !swap_bit) |->
      ((chr_bank[BANK_W +: CORE_W] & $past(xr_wdata)) == $past(xr_wdata)));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($past(rst_n_sync) && !$past(xr_we) && !$past(lat_we)
     && $stable(flat_bit) && $stable(ram_bit) && $stable(ext_bit) && $stable(swap_bit)
     && $stable(outer_lo) && $stable(outer_hi) && $stable(core_r0) && $stable(core_r1)
     && $stable(core_slot)) |-> ($stable(chr_bank) && $stable(chr_ram)));

endmodule

bind chr_bank_xlat chr_bank_xlat_chk #(
  .CORE_W  (CORE_W),
  .BANK_W  (BANK_W),
  .NSLOT   (NSLOT),
  .OUTER_W (OUTER_W)
) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .flat_bit   (ctrl0_i[6]),
  .ram_bit    (ctrl0_i[5]),
  .ext_bit    (ext_ctrl_i[1]),
  .swap_bit   (core_cmd_i[7]),
  .outer_lo   (outer_i[OUTER_W-1:0]),
  .outer_hi   (outer_i[CORE_W-1]),
  .core_r0    (core_r0_i),
  .core_r1    (core_r1_i),
  .core_slot  (core_slot_i),
  .xr_we      (xr_we_i),
  .xr_sel     (xr_sel_i),
  .xr_wdata   (xr_wdata_i),
  .lat_we     (lat_we_i),
  .chr_bank   (chr_bank_o),
  .chr_ram    (chr_ram_o)
);

// File: tb/tb_chr_bank_xlat.sv
module tb_chr_bank_xlat;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ctrl0, outer, ext_ctrl, cmd, r0, r1;
  logic [63:0] core_slot;
  logic        xr_we, xr_sel, lat_we;
  logic [7:0]  xr_wdata;
  logic [1:0]  lat_wdata;
  logic [87:0] bank;
  logic        ram;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2ns clk = ~clk;

  chr_bank_xlat dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl0_i     (ctrl0),
    .outer_i     (outer),
    .ext_ctrl_i  (ext_ctrl),
    .core_cmd_i  (cmd),
    .core_r0_i   (r0),
    .core_r1_i   (r1),
    .core_slot_i (core_slot),
    .xr_we_i     (xr_we),
    .xr_sel_i    (xr_sel),
    .xr_wdata_i  (xr_wdata),
    .lat_we_i    (lat_we),
    .lat_wdata_i (lat_wdata),
    .chr_bank_o  (bank),
    .chr_ram_o   (ram)
  );

  // {ctrl0, outer, ext_ctrl, cmd, seed, r0, r1, req}
  localparam logic [63:0] VEC [11] = '{
    {8'h40, 8'h15, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 8'd1},  // R1 single page
    {8'h44, 8'h80, 8'h00, 8'h00, 8'h33, 8'h00, 8'h00, 8'd1},  // R1 outer bit 7 kept
    {8'h20, 8'h7F, 8'h00, 8'h00, 8'hA0, 8'h00, 8'h00, 8'd2},  // R2 RAM passthrough
    {8'h60, 8'h21, 8'h00, 8'h00, 8'h05, 8'h00, 8'h00, 8'd1},  // R1 wins over RAM bit
    {8'h00, 8'h05, 8'h00, 8'h00, 8'h03, 8'h00, 8'h00, 8'd3},  // R3 offset OR
    {8'h00, 8'hFF, 8'h00, 8'h80, 8'hF8, 8'h00, 8'h00, 8'd3},  // R3 bit 7 dropped, swap ignored
    {8'h00, 8'h02, 8'h02, 8'h00, 8'h40, 8'h11, 8'h22, 8'd4},  // R4 low half substituted
    {8'h00, 8'h02, 8'h02, 8'h80, 8'h40, 8'h11, 8'h22, 8'd5},  // R5 high half substituted
    {8'h40, 8'h09, 8'h02, 8'h80, 8'h70, 8'h11, 8'h22, 8'd10}, // R10 ext ignored, single page
    {8'h20, 8'h00, 8'h02, 8'h00, 8'h90, 8'h11, 8'h22, 8'd10}, // R10 ext ignored, RAM
    {8'h07, 8'h01, 8'hFD, 8'h7F, 8'hC1, 8'h11, 8'h22, 8'd3}   // R3 other bits inert
  };

  function automatic logic [10:0] ref_bank(input logic [7:0] c0, o, e, cm, cv, a0, a1,
                                           input logic [7:0] xa, xb, input logic [1:0] lt,
                                           input int s);
    logic [7:0]  v;
    logic [10:0] offs;
    if (c0[6]) return {(o | {6'b0, lt}), 3'(s)};
    if (c0[5]) return {3'b0, cv};
    offs = {1'b0, o[6:0], 3'b000};
    v = cv;
    if (e[1] && ((s >= 4) == cm[7])) begin
      case (s % 4)
        0:       v = a0;
        1:       v = xa;
        2:       v = a1;
        default: v = xb;
      endcase
    end
    return offs | {3'b0, v};
  endfunction

  function automatic logic [10:0] slot(input int s);
    return bank[s*11 +: 11];
  endfunction

  task automatic check(input logic [10:0] act, input logic [10:0] exp, input string req,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_seed(input logic [7:0] seed);
    for (int s = 0; s < 8; s++) core_slot[s*8 +: 8] = seed + 8'(s * 8'h13);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; ctrl0 = 0; outer = 0; ext_ctrl = 0; cmd = 0; r0 = 0; r1 = 0;
    core_slot = '0; xr_we = 0; xr_sel = 0; xr_wdata = 0; lat_we = 0; lat_wdata = 0;
    do_reset();

    // R6: reset values seen through extension mode and single-page mode
    @(negedge clk);
    ext_ctrl = 8'h02; r0 = 8'h11; r1 = 8'h22;
    #1ns;
    check(slot(1), 11'h0FF, "R6", "extra A after reset");
    check(slot(3), 11'h0FF, "R6", "extra B after reset");
    check(slot(0), 11'h011, "R4", "slot0 from r0");
    ctrl0 = 8'h40;
    #1ns;
    check(slot(0), 11'h000, "R6", "latch cleared");

    // Table walk, registers at their reset values
    for (int i = 0; i < 11; i++) begin
      logic [7:0] seed;
      string rq;
      @(negedge clk);
      {ctrl0, outer, ext_ctrl, cmd, seed, r0, r1} = VEC[i][63:8];
      rq = $sformatf("R%0d", VEC[i][7:0]);
      set_seed(seed);
      #1ns;
      for (int s = 0; s < 8; s++)
        check(slot(s), ref_bank(ctrl0, outer, ext_ctrl, cmd, core_slot[s*8 +: 8], r0, r1,
                                8'hFF, 8'hFF, 2'b00, s), rq, $sformatf("vec %0d slot %0d", i, s));
      check({10'b0, ram}, {10'b0, (!ctrl0[6] && ctrl0[5])}, rq, "ram select");
    end

    // R7: extra register A write, visible only after the edge
    @(negedge clk);
    ctrl0 = 8'h00; outer = 8'h01; ext_ctrl = 8'h02; cmd = 8'h00;
    xr_we = 1; xr_sel = 0; xr_wdata = 8'h3C;
    #1ns;
    check(slot(1), 11'h0FF, "R7", "A before edge");
    @(negedge clk);
    xr_we = 0;
    #1ns;
    check(slot(1), 11'h03C, "R7", "A after edge");
    @(negedge clk);
    xr_we = 1; xr_sel = 1; xr_wdata = 8'h05;
    @(negedge clk);
    xr_we = 0; xr_sel = 0; xr_wdata = 8'hAA;
    #1ns;
    check(slot(3), 11'h00D, "R7", "B after edge");
    @(negedge clk);
    #1ns;
    check(slot(1), 11'h03C, "R7", "A kept with strobe low");
    cmd = 8'h80;
    #1ns;
    check(slot(5), 11'h03C, "R5", "A in high half");
    check(slot(7), 11'h00D, "R5", "B in high half");

    // R8: latch write in single-page mode
    @(negedge clk);
    ctrl0 = 8'h40; outer = 8'h10; lat_we = 1; lat_wdata = 2'b11;
    #1ns;
    check(slot(0), 11'h080, "R8", "latch before edge");
    @(negedge clk);
    lat_we = 0; lat_wdata = 2'b00;
    #1ns;
    check(slot(0), 11'h098, "R8", "latch after edge slot0");
    check(slot(5), 11'h09D, "R8", "latch after edge slot5");
    @(negedge clk);
    #1ns;
    check(slot(0), 11'h098, "R8", "latch kept with strobe low");

    // R9: same-cycle response, no clock edge in between
    @(negedge clk);
    outer = 8'h20;
    #1ns;
    check(slot(0), 11'h118, "R9", "combinational update");

    // R6: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1ns;
    check(slot(0), 11'h100, "R6", "latch cleared by reset");
    ctrl0 = 8'h00; cmd = 8'h00;
    #1ns;
    check(slot(1), 11'h1FF, "R6", "A reloaded with FF");
    check(slot(3), 11'h1FF, "R6", "B reloaded with FF");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #800us;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule